// File: doc/BRIEF.md
# Two-Way Cache Read Path with Per-Set Way Guessing

This block is the read side of a small two-way set-associative cache. Each set keeps one guess bit that names the way to check first. An accepted request spends its first cycle comparing only the guessed way's tag while that way's data word is already steered to the output. When the guess is right, the response is registered at the end of that cycle. When it is wrong, the block holds off new requests, compares the other way in the next cycle, and responds one cycle later. A hit found that way moves the guess to it.

If both ways miss, the response reports a miss after the second cycle and the guess is pointed at the way the next refill will replace. Refills come in on a separate single-cycle port. They write tag, valid and data into the victim chosen by a one-bit per-set LRU, and they win over a request presented in the same cycle. A power-saving input limits the data-array enables to the single way being probed. Three event counters expose how many responses were fast hits, slow hits and misses.

Top module: `wp_cache`

## Requirements
- R1: After reset every set is empty, its guess bit points at way 0 and its LRU bit names way 0 as the next victim. `req_ready` is high, `rsp_valid` is low and all three counters read zero.
- R2: A request whose tag sits in the guessed way returns `rsp_valid=1`, `rsp_hit=1`, `rsp_late=0` and the stored word exactly one cycle after the edge that accepted it. `req_ready` stays high in that probe cycle, so requests can follow back to back. The guessed way becomes most recently used.
- R3: A request whose tag sits only in the other way returns `rsp_hit=1`, `rsp_late=1` and the stored word two cycles after acceptance. The guess bit then names that way, so a repeat of the same address is fast. The other way becomes least recently used.
- R4: A request whose tag is in neither way returns `rsp_hit=0`, `rsp_late=1` and `rsp_data=0` two cycles after acceptance. The set's guess is then set to its current LRU victim way.
- R5: `req_ready` is low in the first-probe cycle of a request that mispredicts and in the retry cycle that follows, so no request is accepted at those edges.
- R6: A refill (`fill_valid` for one cycle, tag and set taken from `fill_addr` as upper and lower bits) writes the LRU victim way of its set and marks it valid. The other way then becomes the next victim.
- R7: While `fill_valid` is high, `req_ready` is low, and a request held in that cycle is not accepted and produces no response.
- R8: `way_rd_en` (bit 0 = way 0, bit 1 = way 1) is zero when no probe is in progress. During a probe cycle it is 2'b11 when `lowpwr_en` is low, and only the probed way's bit when `lowpwr_en` is high. The probed way is the guessed way in the first cycle and the other way in the retry cycle.
- R9: `cnt_first`, `cnt_second` and `cnt_miss` each increase by one in the cycle a fast hit, slow hit or miss response appears, and they are otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lowpwr_en | input | 1 | Enable only the probed way's data array |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address: upper bits tag, lower log2(SETS) bits set |
| req_ready | output | 1 | Request accepted at the next edge when high |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Response found the address |
| rsp_late | output | 1 | Response needed the second probe |
| rsp_data | output | DATA_W | Read word, zero on a miss |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | ADDR_W | Address of the line being installed |
| fill_data | input | DATA_W | Word being installed |
| way_rd_en | output | 2 | Per-way data-array enable |
| cnt_first | output | CNT_W | Fast-hit count |
| cnt_second | output | CNT_W | Slow-hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
The assertions check the rules that hold in every cycle. A refill always blocks the request port. With the power-saving input high, at most one enable is set. A miss is always late and returns zero data. A late response always follows a cycle in which the port was closed. The counters move exactly when a response of their kind appears. Which way a refill lands in, whether a guess is trained correctly, and the exact response cycle and data all depend on history over many accesses. Only the bench's reference model can show these, as it follows sequences of misses, refills, mispredictions and back-to-back hits in shared and separate sets.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_RETRY
    } phase_e;

    typedef struct packed {
        logic upd;
        logic pred;
        logic lru;
    } meta_upd_t;

    function automatic logic [WAYS-1:0] way_mask(input logic w);
        way_mask = w ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/wp_meta_array.sv
module wp_meta_array
    import wp_cache_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic                        rd_pred,
    output logic                        rd_lru,
    input  logic                        fill_we,
    input  logic [IDX_W-1:0]            fill_idx,
    input  logic [TAG_W-1:0]            fill_tag,
    output logic                        fill_way,
    input  meta_upd_t                   upd
);

    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;

    assign fill_way = lru_q[fill_idx];
    assign rd_pred  = pred_q[rd_idx];
    assign rd_lru   = lru_q[rd_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (fill_we && fill_way == 1'(w)) begin
                vld_q[fill_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_we && fill_way == 1'(w)) begin
                tag_q[fill_idx] <= fill_tag;
            end
        end

        assign rd_valid[w] = vld_q[rd_idx];
        assign rd_tag[w]   = tag_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else begin
            if (upd.upd) begin
                pred_q[rd_idx] <= upd.pred;
                if (!(fill_we && fill_idx == rd_idx)) begin
                    lru_q[rd_idx] <= upd.lru;
                end
            end
            if (fill_we) begin
                lru_q[fill_idx] <= ~fill_way;
            end
        end
    end

endmodule

// File: rtl/wp_data_array.sv
module wp_data_array
    import wp_cache_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [WAYS-1:0]              rd_en,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_word,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic                         wr_way,
    input  logic [DATA_W-1:0]            wr_word
);

    for (genvar w = 0; w < WAYS; w++) begin : g_bank
        logic [DATA_W-1:0] mem_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
                mem_q[wr_idx] <= wr_word;
            end
        end

        // A disabled bank drives zero, modelling an unpowered array read.
        assign rd_word[w] = rd_en[w] ? mem_q[rd_idx] : '0;
    end

endmodule

// File: rtl/wp_perf_cnt.sv
module wp_perf_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_first,
    input  logic             inc_second,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] cnt_first,
    output logic [CNT_W-1:0] cnt_second,
    output logic [CNT_W-1:0] cnt_miss
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_first  <= '0;
            cnt_second <= '0;
            cnt_miss   <= '0;
        end else begin
            if (inc_first)  cnt_first  <= cnt_first + 1'b1;
            if (inc_second) cnt_second <= cnt_second + 1'b1;
            if (inc_miss)   cnt_miss   <= cnt_miss + 1'b1;
        end
    end

endmodule

// File: rtl/wp_cache.sv
module wp_cache
    import wp_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SETS   = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lowpwr_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_late,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic [1:0]        way_rd_en,
    output logic [CNT_W-1:0]  cnt_first,
    output logic [CNT_W-1:0]  cnt_second,
    output logic [CNT_W-1:0]  cnt_miss
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    phase_e             phase_q;
    logic [IDX_W-1:0]   idx_q;
    logic [TAG_W-1:0]   tag_q;

    logic [WAYS-1:0]              m_valid;
    logic [WAYS-1:0][TAG_W-1:0]   m_tag;
    logic                         m_pred;
    logic                         m_lru;
    logic                         victim_way;
    logic [WAYS-1:0][DATA_W-1:0]  bank_word;
    meta_upd_t                    upd;

    logic probe_way;
    logic probe_hit;
    logic first_hit;
    logic in_retry;
    logic accept;
    logic rsp_fire;

    assign in_retry  = (phase_q == PH_RETRY);
    assign probe_way = in_retry ? ~m_pred : m_pred;
    assign probe_hit = (phase_q != PH_IDLE) && m_valid[probe_way]
                       && (m_tag[probe_way] == tag_q);
    assign first_hit = (phase_q == PH_FIRST) && probe_hit;
    assign req_ready = !fill_valid && ((phase_q == PH_IDLE) || first_hit);
    assign accept    = req_valid && req_ready;
    assign rsp_fire  = first_hit || in_retry;

    always_comb begin
        if (phase_q == PH_IDLE) begin
            way_rd_en = '0;
        end else if (lowpwr_en) begin
            way_rd_en = way_mask(probe_way);
        end else begin
            way_rd_en = '1;
        end
    end

    always_comb begin
        upd.upd  = rsp_fire;
        upd.pred = m_pred;
        upd.lru  = m_lru;
        if (first_hit) begin
            upd.lru = ~m_pred;
        end else if (in_retry && probe_hit) begin
            upd.pred = ~m_pred;
            upd.lru  = m_pred;
        end else if (in_retry) begin
            upd.pred = m_lru;
        end
    end

    wp_meta_array #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_meta (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx_q),
        .rd_valid (m_valid),
        .rd_tag   (m_tag),
        .rd_pred  (m_pred),
        .rd_lru   (m_lru),
        .fill_we  (fill_valid),
        .fill_idx (fill_addr[IDX_W-1:0]),
        .fill_tag (fill_addr[ADDR_W-1:IDX_W]),
        .fill_way (victim_way),
        .upd      (upd)
    );

    wp_data_array #(
        .SETS   (SETS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (idx_q),
        .rd_en   (way_rd_en),
        .rd_word (bank_word),
        .wr_en   (fill_valid),
        .wr_idx  (fill_addr[IDX_W-1:0]),
        .wr_way  (victim_way),
        .wr_word (fill_data)
    );

    wp_perf_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .inc_first  (first_hit),
        .inc_second (in_retry && probe_hit),
        .inc_miss   (in_retry && !probe_hit),
        .cnt_first  (cnt_first),
        .cnt_second (cnt_second),
        .cnt_miss   (cnt_miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            idx_q     <= '0;
            tag_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_late  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (accept) begin
                phase_q <= PH_FIRST;
                idx_q   <= req_addr[IDX_W-1:0];
                tag_q   <= req_addr[ADDR_W-1:IDX_W];
            end else if (phase_q == PH_FIRST && !probe_hit) begin
                phase_q <= PH_RETRY;
            end else begin
                phase_q <= PH_IDLE;
            end
            rsp_valid <= rsp_fire;
            rsp_hit   <= rsp_fire && probe_hit;
            rsp_late  <= in_retry;
            rsp_data  <= (rsp_fire && probe_hit) ? bank_word[probe_way] : '0;
        end
    end

endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              lowpwr_en,
    input logic              req_ready,
    input logic              fill_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_late,
    input logic [DATA_W-1:0] rsp_data,
    input logic [1:0]        way_rd_en,
    input logic [CNT_W-1:0]  cnt_first,
    input logic [CNT_W-1:0]  cnt_second,
    input logic [CNT_W-1:0]  cnt_miss
);

    assert_fill_blocks_req_R7: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !req_ready);

    assert_single_bank_R8: assert property (@(posedge clk) disable iff (rst)
        lowpwr_en |-> $countones(way_rd_en) <= 1);

    assert_miss_is_late_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_late && rsp_data == '0));

    assert_retry_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_late) |-> $past(!req_ready));

    assert_fast_count_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && !rsp_late) |-> cnt_first == CNT_W'($past(cnt_first) + 1'b1));

    assert_slow_count_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && rsp_late) |-> cnt_second == CNT_W'($past(cnt_second) + 1'b1));

    assert_miss_count_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> cnt_miss == CNT_W'($past(cnt_miss) + 1'b1));

    assert_idle_counts_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> ($stable(cnt_first) && $stable(cnt_second) && $stable(cnt_miss)));

endmodule

bind wp_cache wp_cache_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lowpwr_en  (lowpwr_en),
    .req_ready  (req_ready),
    .fill_valid (fill_valid),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_late   (rsp_late),
    .rsp_data   (rsp_data),
    .way_rd_en  (way_rd_en),
    .cnt_first  (cnt_first),
    .cnt_second (cnt_second),
    .cnt_miss   (cnt_miss)
);

// File: tb/sim_wp_cache.sv
module sim_wp_cache;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NS = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lowpwr_en = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid, rsp_hit, rsp_late;
    logic [DW-1:0] rsp_data;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic [1:0]    way_rd_en;
    logic [CW-1:0] cnt_first, cnt_second, cnt_miss;

    always #5 clk = ~clk;

    wp_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .lowpwr_en(lowpwr_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_late(rsp_late),
        .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .way_rd_en(way_rd_en),
        .cnt_first(cnt_first), .cnt_second(cnt_second), .cnt_miss(cnt_miss)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            at;
        bit            hit;
        bit            late;
        logic [DW-1:0] data;
    } exp_t;
    exp_t exp_q[$];

    bit            m_valid [NS][2];
    logic [7:0]    m_tag   [NS][2];
    logic [DW-1:0] m_data  [NS][2];
    bit            m_pred  [NS];
    bit            m_lru   [NS];
    int            n_first = 0, n_second = 0, n_miss = 0;

    task automatic chk(string req, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Response comparison on every cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
                chk(exp_q[0].late ? (exp_q[0].hit ? "R3" : "R4") : "R2", "rsp_valid", rsp_valid, 1);
                chk("R2", "rsp_hit", rsp_hit, exp_q[0].hit);
                chk("R3", "rsp_late", rsp_late, exp_q[0].late);
                chk("R4", "rsp_data", rsp_data, exp_q[0].data);
                void'(exp_q.pop_front());
            end else begin
                chk("R7", "unexpected rsp_valid", rsp_valid, 0);
            end
        end
    end

    task automatic do_read(input logic [AW-1:0] a);
        int  n;
        int  i;
        bit  p;
        bit  slow;
        exp_t e;
        i = int'(a[3:0]);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        n = cyc;
        p = m_pred[i];
        if (m_valid[i][p] && m_tag[i][p] == a[11:4]) begin
            slow = 0;
            e = '{n + 2, 1'b1, 1'b0, m_data[i][p]};
            m_lru[i] = !p;
            n_first++;
        end else if (m_valid[i][!p] && m_tag[i][!p] == a[11:4]) begin
            slow = 1;
            e = '{n + 3, 1'b1, 1'b1, m_data[i][!p]};
            m_pred[i] = !p;
            m_lru[i]  = p;
            n_second++;
        end else begin
            slow = 1;
            e = '{n + 3, 1'b0, 1'b1, '0};
            m_pred[i] = m_lru[i];
            n_miss++;
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "way_rd_en first probe", way_rd_en, lowpwr_en ? (p ? 2 : 1) : 3);
        chk("R5", "req_ready first probe", req_ready, !slow);
        if (slow) begin
            @(negedge clk);
            chk("R8", "way_rd_en retry", way_rd_en, lowpwr_en ? (p ? 1 : 2) : 3);
            chk("R5", "req_ready retry", req_ready, 0);
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit with_req);
        int i;
        bit v;
        @(negedge clk);
        i = int'(a[3:0]);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_data  = d;
        if (with_req) begin
            req_valid = 1'b1;
            req_addr  = a;
        end
        #1;
        chk("R7", "req_ready during fill", req_ready, 0);
        @(negedge clk);
        fill_valid = 1'b0;
        req_valid  = 1'b0;
        v = m_lru[i];
        m_valid[i][v] = 1'b1;
        m_tag[i][v]   = a[11:4];
        m_data[i][v]  = d;
        m_lru[i]      = !v;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_pred[s] = 0;
            m_lru[s]  = 0;
            m_valid[s][0] = 0;
            m_valid[s][1] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "counters", {cnt_first, cnt_second, cnt_miss}, 0);
        chk("R8", "way_rd_en idle", way_rd_en, 0);

        do_read(12'h051);                 // R4 cold miss
        do_fill(12'h051, 32'hA0A0_0001, 0); // R6 into way 0
        do_read(12'h051);                 // R2 fast
        do_fill(12'h091, 32'hB0B0_0002, 0); // R6 into way 1
        do_read(12'h091);                 // R3 slow, trains guess
        do_read(12'h091);                 // R3 now fast
        do_read(12'h051);                 // R3 slow back to way 0
        do_read(12'h051);                 // R2 back to back
        do_read(12'h051);
        do_read(12'h051);

        lowpwr_en = 1'b1;                 // R8 single-bank mode
        do_read(12'h091);
        do_read(12'h091);
        do_read(12'h051);
        do_read(12'h0C1);                 // R4 miss with low power
        lowpwr_en = 1'b0;

        do_fill(12'h031, 32'hC0C0_0003, 0); // R6 replaces victim
        do_read(12'h031);
        do_read(12'h051);
        do_read(12'h091);
        do_fill(12'h072, 32'hD0D0_0004, 1); // R7 request held with fill
        repeat (3) @(negedge clk);
        do_read(12'h072);

        for (int s = 0; s < NS; s++) begin
            do_fill(AW'((s + 32) * NS + s), 32'h1000 + s, 0);
            do_fill(AW'((s + 64) * NS + s), 32'h2000 + s, 0);
        end
        for (int s = 0; s < NS; s++) begin
            do_read(AW'((s + 32) * NS + s));
            do_read(AW'((s + 64) * NS + s));
            do_read(AW'((s + 64) * NS + s));
            do_read(AW'((s + 96) * NS + s));
        end

        repeat (5) @(negedge clk);
        chk("R2", "pending responses", exp_q.size(), 0);
        chk("R9", "cnt_first", cnt_first, n_first);
        chk("R9", "cnt_second", cnt_second, n_second);
        chk("R9", "cnt_miss", cnt_miss, n_miss);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule